// File: doc/BRIEF.md
# 64-bit Arithmetic Right Shifter with Status Flags

This execution unit joins a 32-bit high word and a 32-bit low word into one 64-bit signed operand, with the high word forming bits 63:32, and shifts it right arithmetically. The distance comes from the low six bits of a 16-bit shift-amount input. The shifted words and three status flags (negative, zero, carry) are registered one clock edge after a start strobe, and a one-cycle done pulse marks the new result.

The unit also holds a repeat counter that the surrounding pipeline may load. The shift cannot be repeated. Suppose a start arrives while the repeat-active input is high. The counter is then forced to zero and the shift runs once only. A start strobe and a done pulse take the place of instruction decode. The operation's opcode value, 16'h562C, is kept as a package constant for the decoder that will drive the strobe.

Top module: `sar64_unit`

## Requirements
- R1: The shift count is `amt_i[5:0]` (0 to 63). Bits 15:6 of `amt_i` have no effect on any output.
- R2: The result `{hi_o, lo_o}` equals `{hi_i, lo_i}` shifted right by the count. Each vacated upper bit is a copy of the operand's original bit 63.
- R3: When the count is 0, `carry_o` is 0 and the result equals the operand.
- R4: When the count is nonzero, `carry_o` equals bit (count-1) of the original 64-bit operand. This is the last bit shifted out.
- R5: `neg_o` equals bit 31 of `hi_o`, which is bit 63 of the result.
- R6: `zero_o` is 1 exactly when all 64 result bits are 0.
- R7: A start with `rpt_active_i` high sets `rpt_cnt_o` to 0 on the same edge that registers the result. Otherwise, `rpt_load_i` loads `rpt_val_i` into the counter, and without a load the counter holds its value.
- R8: Results and flags update on the rising edge at which `start_i` is high. `done_o` is high for exactly that following cycle. Without a start, the outputs hold their values.
- R9: A synchronous active-low reset clears the result words, the flags, `done_o` and the repeat counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Issue one shift |
| hi_i | input | 32 | Operand bits 63:32 |
| lo_i | input | 32 | Operand bits 31:0 |
| amt_i | input | 16 | Shift-amount register; only bits 5:0 are used |
| rpt_active_i | input | 1 | A repeat is pending |
| rpt_load_i | input | 1 | Load the repeat counter |
| rpt_val_i | input | 16 | Value for a counter load |
| hi_o | output | 32 | Result bits 63:32 |
| lo_o | output | 32 | Result bits 31:0 |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Last bit shifted out, or 0 for a zero shift |
| done_o | output | 1 | Result valid pulse |
| rpt_cnt_o | output | 16 | Repeat counter |

## Verification
The corner that is hardest to reach is a carry that sits deep inside the operand. The carry bit comes from bit (count-1), and a random operand rarely tells a correct bit select apart from a neighbouring one. The bench therefore sweeps all 64 counts over four operands: a positive one, a negative one, all ones and zero. Each result is compared against a reference built from a signed shift plus a direct bit select. Hand-picked vectors place lone ones at the 31/32 word seam and at bit 62, so an off-by-one carry or a wrong sign fill is exposed.

// File: rtl/sar64_pkg.sv
package sar64_pkg;
   localparam logic [15:0] SAR64_OPCODE = 16'h562C;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
   } sar_flags_t;
endpackage

// File: rtl/sar64_shift.sv
module sar64_shift #(
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 6,
   parameter bit LOG_STAGE = 1'b1
) (
   input  logic [2*WORD_W-1:0] op_i,
   input  logic [CNT_W-1:0]    cnt_i,
   output logic [2*WORD_W-1:0] res_o,
   output logic                out_bit_o
);
   localparam int OP_W  = 2 * WORD_W;
   localparam int EXT_W = OP_W + 1;

   logic [EXT_W-1:0] ext_res;

   generate
      if (LOG_STAGE) begin : g_log
         logic [EXT_W-1:0] stg [CNT_W+1];
         assign stg[0] = {op_i, 1'b0};
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stg[k+1] = cnt_i[k]
               ? {{SH{stg[k][EXT_W-1]}}, stg[k][EXT_W-1:SH]}
               : stg[k];
         end
         assign ext_res = stg[CNT_W];
      end else begin : g_flat
         logic signed [EXT_W-1:0] ext_op;
         assign ext_op  = {op_i, 1'b0};
         assign ext_res = ext_op >>> cnt_i;
      end
   endgenerate

   assign res_o     = ext_res[EXT_W-1:1];
   assign out_bit_o = ext_res[0];
endmodule

// File: rtl/sar64_flags.sv
module sar64_flags
   import sar64_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [2*WORD_W-1:0] res_i,
   input  logic                out_bit_i,
   output sar_flags_t          flags_o
);
   always_comb begin
      flags_o.neg   = res_i[2*WORD_W-1];
      flags_o.zero  = (res_i == '0);
      flags_o.carry = out_bit_i;
   end
endmodule

// File: rtl/sar64_rpt.sv
module sar64_rpt #(
   parameter int RPT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cancel_i,
   input  logic             load_i,
   input  logic [RPT_W-1:0] load_val_i,
   output logic [RPT_W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_o <= '0;
      else if (cancel_i) cnt_o <= '0;
      else if (load_i)   cnt_o <= load_val_i;
   end
endmodule

// File: rtl/sar64_unit.sv
module sar64_unit
   import sar64_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CTRL_W    = 16,
   parameter int RPT_W     = 16,
   parameter bit LOG_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] hi_i,
   input  logic [WORD_W-1:0] lo_i,
   input  logic [CTRL_W-1:0] amt_i,
   input  logic              rpt_active_i,
   input  logic              rpt_load_i,
   input  logic [RPT_W-1:0]  rpt_val_i,
   output logic [WORD_W-1:0] hi_o,
   output logic [WORD_W-1:0] lo_o,
   output logic              neg_o,
   output logic              zero_o,
   output logic              carry_o,
   output logic              done_o,
   output logic [RPT_W-1:0]  rpt_cnt_o
);
   localparam int OP_W  = 2 * WORD_W;
   localparam int CNT_W = $clog2(OP_W);

   generate
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("sar64_unit: WORD_W must be a power of two of at least 2");
      end
      if (CTRL_W < CNT_W) begin : g_bad_ctrl
         $error("sar64_unit: CTRL_W is too narrow for the shift count");
      end
      if (RPT_W < 1) begin : g_bad_rpt
         $error("sar64_unit: RPT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [OP_W-1:0]  shifted;
   logic             out_bit;
   sar_flags_t       flags_d, flags_q;

   assign cnt = amt_i[CNT_W-1:0];

   sar64_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W), .LOG_STAGE(LOG_STAGE)) shift_i (
      .op_i      ({hi_i, lo_i}),
      .cnt_i     (cnt),
      .res_o     (shifted),
      .out_bit_o (out_bit)
   );

   sar64_flags #(.WORD_W(WORD_W)) flags_i (
      .res_i     (shifted),
      .out_bit_i (out_bit),
      .flags_o   (flags_d)
   );

   sar64_rpt #(.RPT_W(RPT_W)) rpt_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cancel_i   (start_i & rpt_active_i),
      .load_i     (rpt_load_i),
      .load_val_i (rpt_val_i),
      .cnt_o      (rpt_cnt_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_o    <= '0;
         lo_o    <= '0;
         flags_q <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            hi_o    <= shifted[OP_W-1:WORD_W];
            lo_o    <= shifted[WORD_W-1:0];
            flags_q <= flags_d;
         end
      end
   end

   assign neg_o   = flags_q.neg;
   assign zero_o  = flags_q.zero;
   assign carry_o = flags_q.carry;
endmodule

// File: rtl/sar64_chk.sv
module sar64_chk #(
   parameter int WORD_W = 32,
   parameter int CTRL_W = 16,
   parameter int RPT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [WORD_W-1:0] hi_i,
   input logic [CTRL_W-1:0] amt_i,
   input logic              rpt_active_i,
   input logic              rpt_load_i,
   input logic [WORD_W-1:0] hi_o,
   input logic [WORD_W-1:0] lo_o,
   input logic              neg_o,
   input logic              zero_o,
   input logic              carry_o,
   input logic              done_o,
   input logic [RPT_W-1:0]  rpt_cnt_o
);
   localparam int CNT_W = $clog2(2 * WORD_W);

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o); // R8
   AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(hi_o) && $stable(lo_o) && $stable(carry_o))); // R8
   AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> hi_o[WORD_W-1] == $past(hi_i[WORD_W-1])); // R2
   AST_ZERO_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && amt_i[CNT_W-1:0] == '0) |=> !carry_o); // R3
   AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> neg_o == hi_o[WORD_W-1]); // R5
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> zero_o == ({hi_o, lo_o} == '0)); // R6
   AST_RPT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && rpt_active_i) |=> rpt_cnt_o == '0); // R7
   AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !rpt_load_i) |=> $stable(rpt_cnt_o)); // R7
endmodule

bind sar64_unit sar64_chk #(.WORD_W(WORD_W), .CTRL_W(CTRL_W), .RPT_W(RPT_W)) chk_i (.*);

// File: tb/sar64_unit_tb.sv
module sar64_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] hi_i = '0, lo_i = '0;
   logic [15:0] amt_i = '0;
   logic        rpt_active_i = 1'b0, rpt_load_i = 1'b0;
   logic [15:0] rpt_val_i = '0;
   logic [31:0] hi_o, lo_o;
   logic        neg_o, zero_o, carry_o, done_o;
   logic [15:0] rpt_cnt_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sar64_unit dut_i (.*);

   // Hand-computed vectors. Flag encoding {neg, zero, carry}.
   localparam int NV = 5;
   localparam logic [63:0] V_OP  [NV] = '{64'h8000_0000_0000_0000, 64'h1,
                                          64'h4000_0000_0000_0000, 64'hFFFF_FFFF_0000_0001,
                                          64'h0000_0001_8000_0000};
   localparam logic [5:0]  V_CNT [NV] = '{6'd63, 6'd1, 6'd62, 6'd0, 6'd32};
   localparam logic [63:0] V_RES [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1,
                                          64'hFFFF_FFFF_0000_0001, 64'h1};
   localparam logic [2:0]  V_FLG [NV] = '{3'b100, 3'b011, 3'b000, 3'b100, 3'b001};

   localparam logic [63:0] SWEEP_OP [4] = '{64'h3A5C_0F12_9876_5431, 64'hC3A5_0000_1234_8001,
                                           64'hFFFF_FFFF_FFFF_FFFF, 64'h0};

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(logic [63:0] op, logic [15:0] amt, logic ract);
      @(negedge clk);
      {hi_i, lo_i} = op;
      amt_i = amt;
      rpt_active_i = ract;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      rpt_active_i = 1'b0;
   endtask

   task automatic check_ref(logic [63:0] op, logic [5:0] cnt);
      logic signed [63:0] sop;
      logic [63:0] exp;
      logic        c;
      sop = op;
      exp = sop >>> cnt;
      c   = (cnt == 0) ? 1'b0 : op[cnt-1];
      check("R2 result", {hi_o, lo_o}, exp);
      check("R5 neg", 64'(neg_o), 64'(exp[63]));
      check("R6 zero", 64'(zero_o), 64'(exp == 0));
      if (cnt == 0) check("R3 carry zero shift", 64'(carry_o), 64'(c));
      else          check("R4 carry last out", 64'(carry_o), 64'(c));
      check("R8 done pulse", 64'(done_o), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset result", {hi_o, lo_o}, 64'h0);
      check("R9 reset flags", {61'd0, neg_o, zero_o, carry_o}, 64'h0);
      check("R9 reset done/rpt", {47'd0, done_o, rpt_cnt_o}, 64'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run_op(V_OP[i], {10'd0, V_CNT[i]}, 1'b0);
         check("R2 vector result", {hi_o, lo_o}, V_RES[i]);
         check("R4 vector flags", {61'd0, neg_o, zero_o, carry_o}, {61'd0, V_FLG[i]});
      end

      for (int o = 0; o < 4; o++) begin
         for (int c = 0; c < 64; c++) begin
            run_op(SWEEP_OP[o], {10'd0, 6'(c)}, 1'b0);
            check_ref(SWEEP_OP[o], 6'(c));
         end
      end

      // R1: upper control bits ignored
      for (int c = 0; c < 64; c += 9) begin
         run_op(SWEEP_OP[1], {10'h2B7 ^ 10'(c), 6'(c)}, 1'b0);
         check_ref(SWEEP_OP[1], 6'(c));
      end
      run_op(SWEEP_OP[0], 16'hFFC0, 1'b0);
      check("R1 upper bits with count 0", {hi_o, lo_o}, SWEEP_OP[0]);

      // R8: done drops and result holds without a start
      @(negedge clk);
      check("R8 done low when idle", 64'(done_o), 64'd0);
      lo_i = 32'h1234_5678;
      @(negedge clk);
      check("R8 result holds", {hi_o, lo_o}, SWEEP_OP[0]);

      // R7: repeat counter load, hold and cancel
      @(negedge clk);
      rpt_load_i = 1'b1; rpt_val_i = 16'd5;
      @(negedge clk);
      rpt_load_i = 1'b0;
      check("R7 counter load", 64'(rpt_cnt_o), 64'd5);
      run_op(64'h10, 16'd4, 1'b0);
      check("R7 counter holds on plain start", 64'(rpt_cnt_o), 64'd5);
      run_op(64'h10, 16'd4, 1'b1);
      check("R7 counter cancelled", 64'(rpt_cnt_o), 64'd0);
      check("R7 shift once result", {hi_o, lo_o}, 64'h1);
      @(negedge clk);
      check("R7 single done", 64'(done_o), 64'd0);

      // R9: reset mid-run
      run_op(64'hF000_0000_0000_0000, 16'd3, 1'b0);
      @(negedge clk);
      rpt_load_i = 1'b1; rpt_val_i = 16'd9;
      @(negedge clk);
      rpt_load_i = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset clears result", {hi_o, lo_o}, 64'h0);
      check("R9 reset clears flags", {61'd0, neg_o, zero_o, carry_o}, 64'h0);
      check("R9 reset clears counter", 64'(rpt_cnt_o), 64'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule